// File: doc/BRIEF.md
# Systolic GF(2^8) Determinant Engine

This block computes the determinant of a square matrix of 8-bit symbols over GF(2^8), for sizes from 1×1 up to a parameterised maximum (8×8 by default). It is meant to evaluate the determinants of syndrome matrices and their submatrices in an algebraic decoder. Syndrome generation and the choice of submatrix happen outside it.

A `start` pulse samples the matrix size. The matrix then streams in row by row, one element per clock while `in_valid` is high. Internally a single pivot cell and a chain of elimination cells perform Gauss elimination with partial pivoting. The pivot cell takes the first row whose leading element is nonzero and keeps that element as the pivot. Every other row has the pivot row, scaled by a quotient, added to it, which clears its leading column. The reduced rows go into the other half of a two-bank buffer and are streamed back through the same cells for the next, smaller pass. The determinant is the product of the pivots. In characteristic 2 a row exchange does not change the sign, so pivot search costs nothing extra.

When a pass finds no nonzero leading element, the matrix is singular. The block then reports a zero determinant with the singular flag set. In either case the result appears as a single-cycle `out_valid` pulse with registered outputs.

Top module: `det_engine`

## Requirements
- R1: Field arithmetic uses the reduction polynomial x^8+x^4+x^3+x^2+1 (0x11D). Every symbol on the data path is 8 bits.
- R2: A `start` pulse in idle samples `size` (1 to N). The block then accepts exactly size×size elements in row-major order, one on each cycle where `in_valid` is high.
- R3: For a nonsingular matrix, `det_out` equals the determinant over GF(2^8), that is, the sum over all permutations of the products of the selected elements.
- R4: For a singular matrix, `singular` is 1 and `det_out` is 0. For a nonsingular matrix, `singular` is 0 and `det_out` is nonzero.
- R5: A zero leading element in the first row or rows does not stop the elimination. The first later row with a nonzero leading element is taken as the pivot (permutation and anti-diagonal matrices give correct results).
- R6: `out_valid` is high for exactly one cycle per accepted `start`.
- R7: For a nonsingular n×n matrix, `out_valid` rises exactly sum over m=1..n of (m·m+2) clock edges after the edge that accepts the last element.
- R8: A `start` raised while a computation is in progress is ignored. The running result and its timing are unchanged.
- R9: After reset `out_valid`, `singular` and `det_out` are all 0.
- R10: `in_valid` while idle, with no `start`, is ignored and does not disturb the next computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new matrix; sampled only when idle |
| size | input | 4 | Matrix dimension n, 1..N |
| in_valid | input | 1 | Element strobe during loading |
| in_data | input | 8 | Matrix element, row-major |
| out_valid | output | 1 | One-cycle result strobe |
| det_out | output | 8 | Determinant |
| singular | output | 1 | Matrix has no full set of nonzero pivots |

## Verification
A wrong pivot, a bad quotient or a misplaced buffer write corrupts a reduced row. That error carries into a later pivot, so the determinant at the single result strobe differs from the one the bench computes by permutation expansion. Errors in pivot search show up as a false or missing singular flag on zero-leading or rank-deficient matrices. Counter and pass-sequencing errors move the result strobe away from the exact cycle count that is checked for every nonsingular size. Every fault appears within one computation, at most a few hundred cycles after loading.

// File: rtl/detsys_pkg.sv
package detsys_pkg;

  localparam int SYM_W = 8;
  localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [255:0][SYM_W-1:0] inv_tab_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_PEND} st_t;

  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[SYM_W-1] ? ((sh << 1) ^ FIELD_POLY[SYM_W-1:0]) : (sh << 1);
    end
    return acc;
  endfunction

  // a^254 is the inverse of a (and 0 maps to 0)
  function automatic sym_t gf_inv_calc(input sym_t a);
    sym_t r;
    sym_t b;
    logic [7:0] e;
    r = 8'h01;
    b = a;
    e = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, b);
      b = gf_mul(b, b);
    end
    return r;
  endfunction

  function automatic inv_tab_t build_inv();
    inv_tab_t t;
    for (int i = 0; i < 256; i++) t[i] = gf_inv_calc(sym_t'(i));
    return t;
  endfunction

endpackage

// File: rtl/det_pivot_cell.sv
module det_pivot_cell
  import detsys_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic lead,
  input  sym_t x,
  output logic found_o,
  output sym_t axis_o,
  output sym_t q_o,
  output logic prow_o
);

  localparam inv_tab_t INV = build_inv();

  logic found;
  sym_t axis;
  sym_t q;
  logic prow;
  logic take;
  sym_t inv_axis;

  assign take     = en && lead && !found && (x != '0);
  assign inv_axis = INV[axis];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      found <= 1'b0;
      axis  <= '0;
      q     <= '0;
      prow  <= 1'b0;
    end else if (en && lead) begin
      if (take) begin
        found <= 1'b1;
        axis  <= x;
        prow  <= 1'b1;
        q     <= '0;
      end else begin
        prow  <= 1'b0;
        q     <= found ? gf_mul(x, inv_axis) : '0;
      end
    end
  end

  assign found_o = found;
  assign axis_o  = axis;
  assign q_o     = q;
  assign prow_o  = prow;

  // R5
  axis_live_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> axis != '0);

  // R3
  quot_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (en && lead && found) |=> gf_mul(q, axis) == $past(x));

endmodule

// File: rtl/det_elim_cell.sv
module det_elim_cell
  import detsys_pkg::*;
#(
  parameter int CW  = 3,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] col,
  input  logic          prow,
  input  sym_t          x,
  input  sym_t          q,
  output sym_t          term_o
);

  localparam logic [CW-1:0] MY_COL = CW'(IDX + 1);

  sym_t held;

  always_ff @(posedge clk) begin
    if (rst || clr) held <= '0;
    else if (en && prow && col == MY_COL) held <= x;
  end

  assign term_o = gf_mul(q, held);

endmodule

// File: rtl/det_rowbuf.sv
module det_rowbuf
  import detsys_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  sym_t          wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output sym_t          rd
);

  localparam int DEPTH = 1 << AW;

  sym_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rd <= mem[ra];
  end

endmodule

// File: rtl/det_engine.sv
module det_engine
  import detsys_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [$clog2(N+1)-1:0] size,
  input  logic                   in_valid,
  input  logic [7:0]             in_data,
  output logic                   out_valid,
  output logic [7:0]             det_out,
  output logic                   singular
);

  localparam int SW = $clog2(N + 1);
  localparam int RW = (N > 1) ? $clog2(N) : 1;
  localparam int AW = 1 + 2 * RW;
  localparam int NC = N - 1;

  st_t st;
  logic [SW-1:0] m;
  logic [SW-1:0] n_in;
  logic [RW-1:0] lim;
  logic [RW-1:0] lr, lc, rr, rc, wr_r, c1, c1m;
  logic rd_done, v1, last1, cb;
  sym_t det_acc;
  logic iss, clr, load_last, elim_wr;
  logic found, prow;
  sym_t axis, q, rdata, y, term_sel;
  sym_t terms [NC];
  logic we;
  logic [AW-1:0] wa, ra;
  sym_t wd;

  assign n_in = (size == '0 || size > SW'(N)) ? SW'(N) : size;
  assign lim  = RW'(m - SW'(1));
  assign iss  = (st == ST_RUN) && !rd_done;
  assign c1m  = c1 - RW'(1);
  assign load_last = (st == ST_LOAD) && in_valid && lc == lim && lr == lim;
  assign clr  = load_last || (st == ST_PEND && found && m != SW'(1));
  assign elim_wr = v1 && !prow && c1 != '0;

  det_pivot_cell u_piv (
    .clk(clk), .rst(rst), .clr(clr), .en(v1), .lead(c1 == '0), .x(rdata),
    .found_o(found), .axis_o(axis), .q_o(q), .prow_o(prow)
  );

  for (genvar k = 0; k < NC; k++) begin : g_cell
    det_elim_cell #(.CW(RW), .IDX(k)) u_cell (
      .clk(clk), .rst(rst), .clr(clr), .en(v1), .col(c1), .prow(prow),
      .x(rdata), .q(q), .term_o(terms[k])
    );
  end

  always_comb begin
    term_sel = '0;
    for (int k = 0; k < NC; k++) begin
      if (c1 == RW'(k + 1)) term_sel = terms[k];
    end
  end

  assign y  = rdata ^ term_sel;
  assign we = ((st == ST_LOAD) && in_valid) || elim_wr;
  assign wa = (st == ST_LOAD) ? {1'b0, lr, lc} : {~cb, wr_r, c1m};
  assign wd = (st == ST_LOAD) ? in_data : y;
  assign ra = {cb, rr, rc};

  det_rowbuf #(.AW(AW)) u_buf (
    .clk(clk), .we(we), .wa(wa), .wd(wd), .re(iss), .ra(ra), .rd(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      last1 <= 1'b0;
      c1    <= '0;
    end else begin
      v1    <= iss;
      last1 <= iss && rr == lim && rc == lim;
      c1    <= rc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      m         <= SW'(1);
      lr        <= '0;
      lc        <= '0;
      rr        <= '0;
      rc        <= '0;
      wr_r      <= '0;
      rd_done   <= 1'b0;
      cb        <= 1'b0;
      det_acc   <= 8'h01;
      out_valid <= 1'b0;
      det_out   <= '0;
      singular  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            m       <= n_in;
            lr      <= '0;
            lc      <= '0;
            cb      <= 1'b0;
            det_acc <= 8'h01;
            st      <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (in_valid) begin
            if (lc == lim) begin
              lc <= '0;
              if (lr == lim) begin
                rr      <= '0;
                rc      <= '0;
                wr_r    <= '0;
                rd_done <= 1'b0;
                st      <= ST_RUN;
              end else begin
                lr <= lr + RW'(1);
              end
            end else begin
              lc <= lc + RW'(1);
            end
          end
        end
        ST_RUN: begin
          if (iss) begin
            if (rc == lim) begin
              rc <= '0;
              if (rr == lim) rd_done <= 1'b1;
              else rr <= rr + RW'(1);
            end else begin
              rc <= rc + RW'(1);
            end
          end
          if (elim_wr && c1 == lim) wr_r <= wr_r + RW'(1);
          if (v1 && last1) st <= ST_PEND;
        end
        ST_PEND: begin
          if (!found) begin
            out_valid <= 1'b1;
            singular  <= 1'b1;
            det_out   <= '0;
            st        <= ST_IDLE;
          end else if (m == SW'(1)) begin
            out_valid <= 1'b1;
            singular  <= 1'b0;
            det_out   <= gf_mul(det_acc, axis);
            st        <= ST_IDLE;
          end else begin
            det_acc <= gf_mul(det_acc, axis);
            m       <= m - SW'(1);
            cb      <= ~cb;
            rr      <= '0;
            rc      <= '0;
            wr_r    <= '0;
            rd_done <= 1'b0;
            st      <= ST_RUN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R4
  sing_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && singular) |-> det_out == '0);

  // R4
  full_rank_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !singular) |-> det_out != '0);

  // R2
  bank_sep_chk: assert property (@(posedge clk) disable iff (rst)
    (iss && we) |-> ra[AW-1] != wa[AW-1]);

  // R8
  no_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN || st == ST_PEND) |=> st != ST_LOAD);

endmodule

// File: tb/sim_det_engine.sv
module sim_det_engine;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] size = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid;
  logic [7:0] det_out;
  logic singular;

  int errors = 0;
  int checks = 0;
  logic [7:0] mat [8][8];

  always #10 clk = ~clk;

  det_engine #(.N(8)) u0 (
    .clk(clk), .rst(rst), .start(start), .size(size), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .det_out(det_out), .singular(singular)
  );

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      r = r[7] ? ((r << 1) ^ 8'h1D) : (r << 1);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [7:0] perm_prod(input int n, input int p [8]);
    logic [7:0] pr;
    pr = 8'h01;
    for (int r = 0; r < n; r++) pr = fmul(pr, mat[r][p[r]]);
    return pr;
  endfunction

  function automatic logic [7:0] ref_det(input int n);
    int p [8];
    int c [8];
    int i;
    int t;
    int s;
    logic [7:0] sum;
    for (int k = 0; k < 8; k++) begin
      p[k] = k;
      c[k] = 0;
    end
    sum = perm_prod(n, p);
    i = 1;
    while (i < n) begin
      if (c[i] < i) begin
        s = (i % 2 == 0) ? 0 : c[i];
        t = p[s];
        p[s] = p[i];
        p[i] = t;
        sum = sum ^ perm_prod(n, p);
        c[i] = c[i] + 1;
        i = 1;
      end else begin
        c[i] = 0;
        i = i + 1;
      end
    end
    return sum;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mat();
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) mat[r][c] = 8'h00;
  endtask

  task automatic rand_mat(input int n);
    clear_mat();
    for (int r = 0; r < n; r++)
      for (int c = 0; c < n; c++) mat[r][c] = 8'($urandom);
  endtask

  // poke: when nonzero, a start with size 2 is pulsed mid-run (R8)
  task automatic run(input int n, input bit poke);
    logic [7:0] exp_det;
    int exp_lat;
    int k;
    exp_det = ref_det(n);
    exp_lat = 0;
    for (int m = 1; m <= n; m++) exp_lat += m * m + 2;
    @(negedge clk);
    start = 1'b1;
    size = 4'(n);
    @(negedge clk);
    start = 1'b0;
    size = 4'd0;
    for (int r = 0; r < n; r++) begin
      for (int c = 0; c < n; c++) begin
        in_valid = 1'b1;
        in_data = mat[r][c];
        if (!(r == n - 1 && c == n - 1)) @(negedge clk);
      end
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data = 8'h00;
    k = 0;
    while (k < 2000) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      start = (poke && k == 5);
      size = (poke && k == 5) ? 4'd2 : 4'd0;
      if (out_valid) break;
    end
    start = 1'b0;
    size = 4'd0;
    // R2 R3 R5: determinant value
    chk(det_out == exp_det, "R3", det_out, exp_det);
    // R4: singular flag
    chk(singular == (exp_det == 8'h00), "R4", singular, exp_det == 8'h00);
    // R7: exact latency for nonsingular
    if (exp_det != 8'h00) chk(k == exp_lat, "R7", k, exp_lat);
    @(negedge clk);
    // R6: single-cycle strobe
    chk(!out_valid, "R6", out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(!out_valid && !singular && det_out == 8'h00, "R9",
        {out_valid, singular, det_out}, 0);

    // R10: stray in_valid while idle
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1;
      in_data = 8'hA5 + 8'(i);
      @(negedge clk);
    end
    in_valid = 1'b0;
    clear_mat();
    for (int i = 0; i < 3; i++) mat[i][i] = 8'h01;
    mat[0][1] = 8'h07;
    run(3, 0); // R10: result unaffected

    // R1: 1x1 and 2x2 arithmetic cases
    clear_mat(); mat[0][0] = 8'h53; run(1, 0);
    clear_mat(); mat[0][0] = 8'h00; run(1, 0);
    clear_mat();
    mat[0][0] = 8'h02; mat[0][1] = 8'h03; mat[1][0] = 8'h80; mat[1][1] = 8'hC5;
    run(2, 0); // R1 uses reduction by 0x11D

    // R5: zero leading entries need pivot search
    clear_mat();
    for (int i = 0; i < 4; i++) mat[i][3 - i] = 8'h11 + 8'(i);
    run(4, 0);
    rand_mat(5); mat[0][0] = 8'h00; mat[1][0] = 8'h00; run(5, 0);
    rand_mat(6);
    for (int r = 0; r < 6; r++) mat[r][1] = 8'h00;
    mat[0][0] = 8'h00; run(6, 0);

    // R4: singular cases
    rand_mat(5);
    for (int c = 0; c < 5; c++) mat[4][c] = mat[1][c];
    run(5, 0);
    rand_mat(4);
    for (int c = 0; c < 4; c++) mat[3][c] = mat[0][c] ^ mat[2][c];
    run(4, 0);
    clear_mat(); run(8, 0);
    rand_mat(7);
    for (int r = 0; r < 7; r++) mat[r][6] = 8'h00;
    run(7, 0);

    // R8: start while busy ignored
    rand_mat(6); run(6, 1);

    // R2 R3: random sweep over every size
    for (int n = 1; n <= 8; n++) begin
      for (int t = 0; t < 3; t++) begin
        rand_mat(n);
        run(n, 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule